// File: doc/BRIEF.md
# I2C Open-Drain Port Expander Target

This block is an I2C target that owns eight open-drain port pins. Each pin is modelled as a pair: the pad level comes in on `pin_i`, and a pull-low enable goes out on `pin_oe`. SCL and SDA each pass through a two-flop synchronizer. START and STOP are found on the synchronized lines, and a 7-bit target address is matched. The upper address bits come from a parameter and the low bits from strap inputs.

In a write, every data byte after the address is acknowledged and loaded straight into the port latch. A zero latch bit pulls its pin low. A one latch bit releases the pin, so the pin can be used as an input.

When the address is acknowledged, the block captures a snapshot of the synchronized pin levels and releases the open-drain interrupt. The interrupt is pulled low again as soon as any synchronized pin level differs from that snapshot. A read transaction returns the snapshot byte, once per byte the controller requests.

Top module: `odio_expander`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `pin_oe` is 8'h00 (latch all ones), `irq_oe` is 0 and `sda_oe` is 0.
- R2: A 7-bit address equal to {ADDR_BASE[6:STRAP_W], addr_strap}, sent MSB first, is acknowledged. The block pulls SDA low (`sda_oe`=1) for the ninth clock.
- R3: A non-matching address is not acknowledged. Any bytes that follow are neither acknowledged nor applied to the port until the next START.
- R4: In a write (R/W bit 0), each data byte is acknowledged. At the acknowledge clock its value is loaded into the latch, and `pin_oe[i]` equals the inverse of latch bit i.
- R5: Any number of data bytes may follow one address. Each one replaces the port value in turn until STOP.
- R6: At the address acknowledge clock, the synchronized pin levels are captured. In a read (R/W bit 1), that snapshot is returned MSB first, and it is sent again for each byte the controller acknowledges.
- R7: After a controller NACK in a read, SDA is released. Further clocks are ignored until STOP or START.
- R8: `irq_oe` goes to 1 when a synchronized pin level differs from the snapshot. It stays at 1 even if the pins return to the snapshot value, and it returns to 0 at the next address acknowledge.
- R9: A repeated START restarts address reception and discards any partially received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_strap | input | STRAP_W | Low bits of the target address |
| pin_i | input | 8 | Port pad levels |
| pin_oe | output | 8 | 1 pulls the port pin low |
| irq_oe | output | 1 | 1 pulls the interrupt line low |

## Verification
The bench uses the default parameters: a base address of 7'h68 and two strap bits. That is small enough to try all 128 addresses, each followed by a data byte, so every acknowledge and every ignored byte can be predicted from the address alone. All four strap values are tried, each against its matching address and a neighbouring one. Reads use a fixed set of external pin levels, so the expected snapshot follows directly from those levels and the port latch.

// File: rtl/odio_expander.sv
module odio_expander #(
  parameter logic [6:0] ADDR_BASE = 7'h68,
  parameter int STRAP_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] addr_strap,
  input  logic [7:0]         pin_i,
  output logic [7:0]         pin_oe,
  output logic               irq_oe
);
  typedef enum logic [2:0] {IDLE, ADDR, AACK, WDAT, WACK, RDAT, RACK, SKIP} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  logic [7:0] pin_m, pin_s;
  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sh, port_q, snap;
  logic       rw, sda_q, irq_q, more;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sy <= '1; sda_sy <= '1; scl_d <= 1'b1; sda_d <= 1'b1;
      pin_m <= '1; pin_s <= '1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_sy[1];
      sda_d  <= sda_sy[1];
      pin_m  <= pin_i;
      pin_s  <= pin_m;
    end
  end

  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];
  wire rise  = scl_s & ~scl_d;
  wire fall  = ~scl_s & scl_d;
  wire start = scl_s & scl_d & sda_d & ~sda_s;
  wire stop  = scl_s & scl_d & ~sda_d & sda_s;
  wire [6:0] my_addr = {ADDR_BASE[6:STRAP_W], addr_strap};
  wire capture = (st == AACK) && rise && !start && !stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= IDLE; cnt <= '0; sh <= '0; port_q <= '1; snap <= '1;
      rw <= 1'b0; sda_q <= 1'b0; more <= 1'b0;
    end else if (start) begin
      st <= ADDR; cnt <= '0; sda_q <= 1'b0;
    end else if (stop) begin
      st <= IDLE; sda_q <= 1'b0;
    end else begin
      case (st)
        ADDR, WDAT: begin
          if (rise && cnt != 4'd8) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (fall && cnt == 4'd8) begin
            cnt <= '0;
            if (st == WDAT) begin
              st <= WACK; sda_q <= 1'b1;
            end else if (sh[7:1] == my_addr) begin
              st <= AACK; sda_q <= 1'b1; rw <= sh[0];
            end else begin
              st <= SKIP;
            end
          end
        end
        AACK: begin
          if (rise) snap <= pin_s;
          else if (fall) begin
            if (rw) begin
              st <= RDAT; sh <= snap; sda_q <= ~snap[7];
            end else begin
              st <= WDAT; sda_q <= 1'b0;
            end
          end
        end
        WACK: begin
          if (rise) port_q <= sh;
          else if (fall) begin
            st <= WDAT; sda_q <= 1'b0;
          end
        end
        RDAT: begin
          if (fall) begin
            if (cnt == 4'd7) begin
              st <= RACK; sda_q <= 1'b0; cnt <= '0;
            end else begin
              sh <= {sh[6:0], 1'b0}; sda_q <= ~sh[6]; cnt <= cnt + 4'd1;
            end
          end
        end
        RACK: begin
          if (rise) more <= ~sda_s;
          else if (fall) begin
            if (more) begin
              st <= RDAT; sh <= snap; sda_q <= ~snap[7];
            end else begin
              st <= SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else if (capture) irq_q <= 1'b0;
    else if (pin_s != snap) irq_q <= 1'b1;
  end

  assign sda_oe = sda_q;
  assign pin_oe = ~port_q;
  assign irq_oe = irq_q;
endmodule

// File: rtl/odio_expander_chk.sv
module odio_expander_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl_i,
  input logic       sda_oe,
  input logic [7:0] pin_oe,
  input logic       irq_oe
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (pin_oe == 8'h00 && !irq_oe && !sda_oe));

  assert_sda_moves_scl_low_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i);

  assert_port_loads_scl_high_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(pin_oe) |-> scl_i);

  assert_irq_clears_at_ack_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_oe) |-> scl_i);

  assert_ack_low_only_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $stable(pin_oe));
endmodule

bind odio_expander odio_expander_chk u_chk (.*);

// File: tb/test_odio_expander.sv
module test_odio_expander;
  localparam int Q = 6;
  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'b01;
  logic [7:0] ext = 8'hFF;
  logic sda_oe, irq_oe;
  logic [7:0] pin_oe;
  wire sda_line = sda_m & ~sda_oe;
  wire [7:0] pin_lvl = ext & ~pin_oe;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  odio_expander i_odio_expander (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_strap(strap), .pin_i(pin_lvl), .pin_oe(pin_oe), .irq_oe(irq_oe));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic i_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic i_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic wbit(input logic b);
    sda_m = b; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); b = sda_line; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic wbyte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic rbyte(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      v[i] = b;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] rv, port_exp, d;
    wq(4);
    chk("R1 pin_oe in reset", {24'd0, pin_oe}, 32'h00);
    chk("R1 irq_oe in reset", {31'd0, irq_oe}, 32'd0);
    chk("R1 sda_oe in reset", {31'd0, sda_oe}, 32'd0);
    rst = 1'b0;
    wq(4);
    port_exp = 8'hFF;

    // R2 R3: all 128 addresses with one data byte each
    for (int a = 0; a < 128; a++) begin
      d = 8'(a * 2 + 1) ^ 8'hC3;
      i_start();
      wbyte({7'(a), 1'b0}, ack);
      chk("R2 R3 address ack", {31'd0, ack}, {31'd0, (a == 'h69)});
      wbyte(d, ack);
      chk("R3 R4 data ack", {31'd0, ack}, {31'd0, (a == 'h69)});
      i_stop();
      if (a == 'h69) port_exp = d;
      chk("R3 R4 port after byte", {24'd0, pin_oe}, {24'd0, ~port_exp});
    end

    // R2: every strap value, matching and neighbouring address
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      d = {2'(s), 6'h2A};
      i_start();
      wbyte({5'b11010, 2'(s), 1'b0}, ack);
      chk("R2 strap match ack", {31'd0, ack}, 32'd1);
      wbyte(d, ack);
      i_stop();
      chk("R2 R4 strap port", {24'd0, pin_oe}, {24'd0, ~d});
      i_start();
      wbyte({5'b11010, 2'(s) ^ 2'b10, 1'b0}, ack);
      chk("R2 strap mismatch nack", {31'd0, ack}, 32'd0);
      i_stop();
    end
    strap = 2'b01;

    // R5: several bytes in one write
    i_start();
    wbyte(8'hD2, ack);
    wbyte(8'h12, ack);
    chk("R5 first byte", {24'd0, pin_oe}, {24'd0, ~8'h12});
    wbyte(8'h34, ack);
    chk("R5 second byte", {24'd0, pin_oe}, {24'd0, ~8'h34});
    wbyte(8'hFF, ack);
    chk("R5 third byte ack", {31'd0, ack}, 32'd1);
    chk("R5 third byte", {24'd0, pin_oe}, 32'h00);
    i_stop();

    // R9: repeated START during address and during data
    i_start();
    wbit(1'b1); wbit(1'b1); wbit(1'b0); wbit(1'b0);
    i_start();
    wbyte(8'hD2, ack);
    chk("R9 restarted address ack", {31'd0, ack}, 32'd1);
    wbit(1'b0); wbit(1'b0); wbit(1'b0); wbit(1'b0);
    i_start();
    chk("R9 partial byte dropped", {24'd0, pin_oe}, 32'h00);
    wbyte(8'hD2, ack);
    wbyte(8'h3C, ack);
    chk("R9 byte after restart", {24'd0, pin_oe}, {24'd0, ~8'h3C});
    wbyte(8'hFF, ack);
    i_stop();

    // R6 R7: read the snapshot
    ext = 8'hA5;
    wq(10);
    i_start();
    wbyte(8'hD3, ack);
    chk("R6 read address ack", {31'd0, ack}, 32'd1);
    rbyte(rv);
    chk("R6 first snapshot byte", {24'd0, rv}, 32'hA5);
    wbit(1'b0);
    ext = 8'h0F;
    rbyte(rv);
    chk("R6 repeated snapshot byte", {24'd0, rv}, 32'hA5);
    wbit(1'b1);
    chk("R7 sda released after nack", {31'd0, sda_oe}, 32'd0);
    rbyte(rv);
    chk("R7 bus ignored after nack", {24'd0, rv}, 32'hFF);
    i_stop();

    // R8: interrupt behaviour
    ext = 8'hFF;
    wq(10);
    i_start();
    wbyte(8'hD2, ack);
    chk("R8 irq cleared at ack", {31'd0, irq_oe}, 32'd0);
    i_stop();
    ext = 8'hF7;
    wq(10);
    chk("R8 irq on pin change", {31'd0, irq_oe}, 32'd1);
    ext = 8'hFF;
    wq(10);
    chk("R8 irq held after pin returns", {31'd0, irq_oe}, 32'd1);
    i_start();
    wbyte(8'hD2, ack);
    chk("R8 irq cleared at next ack", {31'd0, irq_oe}, 32'd0);
    i_stop();
    wq(10);
    chk("R8 irq stays clear", {31'd0, irq_oe}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule